// File: doc/BRIEF.md
# Four-Lane Configurable Serializer with Word Clock

The block turns parallel words into serial bit streams on four independent transmit lanes. Each lane has its own 8-bit control byte and its own 10-bit data bus. The lane captures a word, sends it one bit per bit slot with the least significant bit first, and drives a word-rate clock whose rising edge marks the slot where the next word is captured. The input clock stands for the half-cycles of a fast serial PLL. A clock-enable divider stretches one bit slot to 1, 2 or 4 input cycles for full, half or quarter rate.

The control byte selects 10-bit or 8-bit framing. In 8-bit framing the word comes from the upper eight data bits. The byte also selects the rate and can invert the output polarity. A lane that is disabled or set to a reserved code goes quiet at once. A change between valid settings waits for the end of the word in flight, so a word is never cut short. Reconfiguration is safe while the lane runs.

Top module: `sertx_quad`

## Requirements
- R1: After reset every control field is treated as 0 and all outputs (tx_p, tx_n, wclk) are 0.
- R2: With width code 000 (control bits 4:2) a word is data bits [9:0], sent bit 0 first, one bit per slot, ten slots per word.
- R3: With width code 001 a word is data bits [9:2], sent bit 2 first, eight slots per word. Data bits [1:0] have no effect on the output.
- R4: In 10-bit framing wclk is high for the first 4 slots of each word and low for the following 6.
- R5: In 8-bit framing wclk is high for the first 4 slots of each word and low for the following 4.
- R6: Rate code (control bits 6:5) 00, 01 and 10 gives a bit slot of 1, 2 and 4 clock cycles.
- R7: With invert (control bit 7) set, tx_p carries the complement of each data bit. While running, tx_n is always the complement of tx_p.
- R8: With enable (control bit 0) low, one cycle later tx_p, tx_n and wclk are 0. On enable, the next cycle starts a fresh word: wclk high and the first bit of the word on tx_p.
- R9: Width codes 010 to 111 and rate code 11 are reserved. Either one puts the lane in the disabled state of R8 from the next cycle.
- R10: A change between valid settings takes effect at the next word boundary. The word in flight finishes with its old width, rate and polarity.
- R11: Each lane runs only from its own control byte (bits 8k+7:8k) and data bus (bits 10k+9:10k). Lanes with different settings run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one period per PLL half-cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_ctrl | input | NUM_LANES*8 | Control bytes, lane k at bits 8k+7:8k |
| lane_data | input | NUM_LANES*10 | Parallel words, lane k at bits 10k+9:10k |
| tx_p | output | NUM_LANES | Positive serial leg per lane |
| tx_n | output | NUM_LANES | Negative serial leg per lane (0 when idle) |
| wclk | output | NUM_LANES | Word clock per lane |

## Verification
The main function is run with eight pairs of control byte and data. Together they cover each width at each rate, with and without inversion, and with data chosen so that a bit-order or slot-length error changes the serial pattern. Two 8-bit vectors differ only in data bits [1:0], so they separate correct upper-bit selection from a leak of the low bits. Each vector runs for two full words, so a word clock with the wrong high or low length, or a slip at the word boundary, shows up. Directed runs change settings mid-word, program reserved codes, disable and re-enable a lane, and run two lanes with different settings together.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int WORD_W     = 10;
    localparam int NARROW_W   = 8;
    localparam int CTRL_W     = 8;
    localparam int WCLK_HIGH  = 4;
    localparam int CNT_W      = $clog2(WORD_W);
    localparam int DIV_W      = 2;

    localparam int EN_BIT     = 0;
    localparam int WIDTH_LSB  = 2;
    localparam int RATE_LSB   = 5;
    localparam int INV_BIT    = 7;

    localparam logic [2:0] WSEL_TEN   = 3'b000;
    localparam logic [2:0] WSEL_EIGHT = 3'b001;
    localparam logic [1:0] RATE_BAD   = 2'b11;

    typedef struct packed {
        logic       en;
        logic [2:0] width;
        logic [1:0] rate;
        logic       inv;
    } lane_cfg_t;

    typedef struct packed {
        logic              run;
        logic              wide;
        logic [1:0]        rate;
        logic              inv;
        logic [CNT_W-1:0]  bitc;
        logic [WORD_W-1:0] shreg;
        logic              ser;
        logic              wclk;
    } lane_st_t;

    function automatic lane_cfg_t cfg_decode(input logic [CTRL_W-1:0] c);
        lane_cfg_t r;
        r.en    = c[EN_BIT];
        r.width = c[WIDTH_LSB +: 3];
        r.rate  = c[RATE_LSB +: 2];
        r.inv   = c[INV_BIT];
        return r;
    endfunction

    function automatic logic cfg_usable(input lane_cfg_t c);
        return c.en && (c.width == WSEL_TEN || c.width == WSEL_EIGHT)
               && (c.rate != RATE_BAD);
    endfunction

    // Terminal count of the slot divider: slot lasts lim+1 cycles.
    function automatic logic [DIV_W-1:0] slot_lim(input logic [1:0] rate);
        case (rate)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/sertx_slot_div.sv
module sertx_slot_div
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim    = slot_lim(rate_i);
        tick_o = run_i && (div_q == lim);
        if (!run_i || tick_o) div_d = '0;
        else                  div_d = div_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R6: divider never passes the terminal count of the running rate
    assert_div_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (div_q <= lim));
    // R8: an idle lane leaves the divider at zero for a clean restart
    assert_div_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (div_q == '0));
endmodule

// File: rtl/sertx_lane.sv
module sertx_lane
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              tick_i,
    output logic              run_o,
    output logic [1:0]        rate_o,
    output logic              tx_p_o,
    output logic              tx_n_o,
    output logic              wclk_o
);
    lane_st_t          st_d, st_q;
    lane_cfg_t         cfg;
    logic              ok;
    logic              boundary;
    logic [CNT_W-1:0]  last;
    logic [WORD_W-1:0] sel;

    always_comb begin
        cfg      = cfg_decode(ctrl_i);
        ok       = cfg_usable(cfg);
        last     = st_q.wide ? CNT_W'(WORD_W - 1) : CNT_W'(NARROW_W - 1);
        boundary = st_q.run && tick_i && (st_q.bitc == last);
        sel      = (cfg.width == WSEL_TEN) ? data_i
                                           : WORD_W'(data_i[WORD_W-1 -: NARROW_W]);
        st_d     = st_q;
        if (!ok) begin
            st_d = '0;
        end else if (!st_q.run || boundary) begin
            st_d.run   = 1'b1;
            st_d.wide  = (cfg.width == WSEL_TEN);
            st_d.rate  = cfg.rate;
            st_d.inv   = cfg.inv;
            st_d.bitc  = '0;
            st_d.ser   = sel[0] ^ cfg.inv;
            st_d.shreg = sel >> 1;
            st_d.wclk  = 1'b1;
        end else if (tick_i) begin
            st_d.bitc  = st_q.bitc + CNT_W'(1);
            st_d.ser   = st_q.shreg[0] ^ st_q.inv;
            st_d.shreg = st_q.shreg >> 1;
            st_d.wclk  = (st_q.bitc + CNT_W'(1)) < CNT_W'(WCLK_HIGH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o  = st_q.run;
    assign rate_o = st_q.rate;
    assign tx_p_o = st_q.ser;
    assign tx_n_o = st_q.run & ~st_q.ser;
    assign wclk_o = st_q.wclk;

    // R8/R9: an unusable control byte silences the lane on the next cycle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |=> (!tx_p_o && !tx_n_o && !wclk_o));
    // R8: a lane always (re)starts at the first slot of a word
    assert_restart_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> (st_q.wclk && st_q.bitc == '0));
    // R10: latched settings move only at a word boundary
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !boundary && ok) |=> $stable({st_q.wide, st_q.rate, st_q.inv}));
    // R4/R5: word clock rises only together with a fresh word
    assert_wclk_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wclk_o) |-> (st_q.bitc == '0));
endmodule

// File: rtl/sertx_quad.sv
module sertx_quad
    import sertx_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LANES*CTRL_W-1:0]   lane_ctrl,
    input  logic [NUM_LANES*WORD_W-1:0]   lane_data,
    output logic [NUM_LANES-1:0]          tx_p,
    output logic [NUM_LANES-1:0]          tx_n,
    output logic [NUM_LANES-1:0]          wclk
);
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic       run;
        logic [1:0] rate;
        logic       tick;

        sertx_slot_div u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run),
            .rate_i (rate),
            .tick_o (tick)
        );

        sertx_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (lane_ctrl[k*CTRL_W +: CTRL_W]),
            .data_i (lane_data[k*WORD_W +: WORD_W]),
            .tick_i (tick),
            .run_o  (run),
            .rate_o (rate),
            .tx_p_o (tx_p[k]),
            .tx_n_o (tx_n[k]),
            .wclk_o (wclk[k])
        );
    end
endmodule

// File: tb/sertx_quad_bench.sv
module sertx_quad_bench;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL*8-1:0]  lane_ctrl = '0;
    logic [NL*10-1:0] lane_data = '0;
    logic [NL-1:0] tx_p, tx_n, wclk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sertx_quad #(.NUM_LANES(NL)) u_sertx_quad (
        .clk(clk), .rst_n(rst_n), .lane_ctrl(lane_ctrl), .lane_data(lane_data),
        .tx_p(tx_p), .tx_n(tx_n), .wclk(wclk)
    );

    // {ctrl, data}: ctrl bit0 enable, [4:2] width, [6:5] rate, [7] invert
    localparam logic [17:0] VEC [8] = '{
        {8'h01, 10'h2D3},   // 10-bit full
        {8'h21, 10'h155},   // 10-bit half
        {8'h41, 10'h0F1},   // 10-bit quarter
        {8'h05, 10'h3A7},   // 8-bit full, low bits set
        {8'hA5, 10'h1C2},   // 8-bit half, inverted
        {8'h45, 10'h2FF},   // 8-bit quarter
        {8'h81, 10'h001},   // 10-bit full, inverted
        {8'h05, 10'h3A4}    // 8-bit full, low bits differ from entry 3
    };

    function automatic int wlen(input logic [7:0] c);
        return (c[4:2] == 3'b001) ? 8 : 10;
    endfunction
    function automatic int slen(input logic [7:0] c);
        return (c[6:5] == 2'b00) ? 1 : (c[6:5] == 2'b01) ? 2 : 4;
    endfunction
    // expected {tx_p, tx_n, wclk} at cycle cyc after the start edge
    function automatic logic [2:0] model(input logic [7:0] c, input logic [9:0] d, input int cyc);
        int  slot = (cyc / slen(c)) % wlen(c);
        logic b = (wlen(c) == 8) ? d[slot + 2] : d[slot];
        logic p = b ^ c[7];
        return {p, ~p, (slot < 4)};
    endfunction

    task automatic check(input logic cond, input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: got {p,n,w}=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] obs(input int lane);
        return {tx_p[lane], tx_n[lane], wclk[lane]};
    endfunction

    task automatic set_lane(input int lane, input logic [7:0] c, input logic [9:0] d);
        lane_ctrl[lane*8 +: 8]  = c;
        lane_data[lane*10 +: 10] = d;
    endtask

    // called at a negedge; sets the lane and checks ncyc cycles
    task automatic run_lane(input int lane, input logic [7:0] c, input logic [9:0] d,
                            input int ncyc, input string req);
        set_lane(lane, c, d);
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            @(negedge clk);
            check(obs(lane) == model(c, d, cyc), req, obs(lane), model(c, d, cyc));
        end
    endtask

    task automatic idle_lane(input int lane, input logic [7:0] c, input int ncyc, input string req);
        lane_ctrl[lane*8 +: 8] = c;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            check(obs(lane) == 3'b000, req, obs(lane), 3'b000);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        logic [9:0] d;
        repeat (3) @(negedge clk);
        check(tx_p == '0 && tx_n == '0 && wclk == '0, "R1 reset", obs(0), 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_p == '0 && tx_n == '0 && wclk == '0, "R1 after reset", obs(0), 3'b000);

        // table walk: each vector from idle, two full words
        for (int v = 0; v < 8; v++) begin
            c = VEC[v][17:10];
            d = VEC[v][9:0];
            idle_lane(0, 8'h00, 2, "R8 idle");
            run_lane(0, c, d, 2 * wlen(c) * slen(c),
                     (wlen(c) == 8) ? "R3 R5 R6 R7" : "R2 R4 R6 R7");
        end

        // R10: switch 10-bit full to 8-bit half inverted mid-word
        idle_lane(0, 8'h00, 2, "R8 idle");
        set_lane(0, 8'h01, 10'h2B6);
        for (int cyc = 0; cyc < 10; cyc++) begin
            @(negedge clk);
            check(obs(0) == model(8'h01, 10'h2B6, cyc), "R10 old word", obs(0), model(8'h01, 10'h2B6, cyc));
            if (cyc == 3) lane_ctrl[7:0] = 8'hA5;
        end
        for (int cyc = 0; cyc < 32; cyc++) begin
            @(negedge clk);
            check(obs(0) == model(8'hA5, 10'h2B6, cyc), "R10 new word", obs(0), model(8'hA5, 10'h2B6, cyc));
        end

        // R9: reserved width then reserved rate, each mid-word
        run_lane(0, 8'h01, 10'h3FF, 3, "R2 pre-reserved");
        idle_lane(0, 8'h09, 4, "R9 width 010");
        run_lane(0, 8'h01, 10'h3FF, 3, "R8 restart");
        idle_lane(0, 8'h61, 4, "R9 rate 11");
        idle_lane(0, 8'h1D, 3, "R9 width 111");

        // R8: disable mid-word with invert set, then clean restart
        run_lane(0, 8'h81, 10'h000, 5, "R7 pre-disable");
        idle_lane(0, 8'h80, 4, "R8 disabled");
        run_lane(0, 8'h21, 10'h1A5, 20, "R8 restart at word start");

        // R11: two lanes at once with different settings
        idle_lane(0, 8'h00, 1, "R8 idle");
        set_lane(1, 8'hA5, 10'h0C3);
        set_lane(0, 8'h01, 10'h35A);
        for (int cyc = 0; cyc < 48; cyc++) begin
            @(negedge clk);
            check(obs(0) == model(8'h01, 10'h35A, cyc), "R11 lane0", obs(0), model(8'h01, 10'h35A, cyc));
            check(obs(1) == model(8'hA5, 10'h0C3, cyc), "R11 lane1", obs(1), model(8'hA5, 10'h0C3, cyc));
            check(obs(2) == 3'b000, "R11 lane2 idle", obs(2), 3'b000);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule